// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one down-counting timer channel that a processor programs over a byte-wide bus. The bus has chip select, read and write strobes and two address bits. Three addresses reach the counters and the fourth reaches a shared control register. The channel answers the counter address equal to its `CH_ID` parameter, and it also answers control bytes whose counter-select field names that ID. A control byte sets the byte access format, one of six operating modes, and binary or decimal (BCD) counting. The processor then writes the initial count as a low byte, a high byte, or both in turn.

Counting moves only on cycles where `cnt_tick` is high. This input is the sampled counting clock. `gate` enables or triggers counting, depending on the mode, and `out` carries the waveform for the mode. The processor can read the live count back through the counter address in the same byte order used for writes. Bus strobes are sampled on `clk`, and each cycle with a strobe low counts as one access.

Top module: `pit_channel`

## Requirements
- R1: After reset, `out` is 1 and `dout` is 0. Reads of the counter before any control byte has been accepted return 0.
- R2: A control byte is a write to address 3 with `cs_n` low. Its fields are: bits 7:6 the counter select (must equal CH_ID), bits 5:4 the access format (01 low byte only, 10 high byte only, 11 low then high), bits 3:1 the mode (000 mode 0, 001 mode 1, x10 mode 2, x11 mode 3, 100 mode 4, 101 mode 5) and bit 0 BCD. A byte that names another counter, a byte with access field 00, and any write with `cs_n` high are all ignored.
- R3: The count written in low-only format has a high byte of 0. In high-only format it has a low byte of 0. A loaded value of 0 stands for 65536 in binary or 10000 in BCD.
- R4: A read of the counter address returns the current count. In format 11, successive reads return the low byte and then the high byte. In format 10 a read returns the high byte.
- R5: Mode 0: `out` goes low on the cycle after the count write. It stays low for N ticks, goes high, and stays high until a new control byte or count.
- R6: Mode 0: ticks taken while `gate` is low do not decrement the count. This lengthens the low time by the same number of ticks.
- R7: Mode 1: a rising `gate` edge loads N and drives `out` low for N ticks, after which `out` goes high. Another rising edge during the count restarts it at N.
- R8: Mode 2, with `gate` high: `out` is high for N-1 ticks, then low for exactly one tick, and the count reloads by itself (N >= 2).
- R9: Mode 3 (N >= 2): `out` is high for ceil(N/2) ticks and low for floor(N/2) ticks, repeating.
- R10: Mode 4: after the count write, `out` stays high for N ticks, goes low for one tick, and then stays high. There is no reload.
- R11: Mode 5: nothing happens until a rising `gate` edge. From that edge `out` is high for N ticks, then low for one tick. A new rising edge during the count restarts it.
- R12: In modes 2 and 3, a tick with `gate` low forces `out` high and holds the count. The next rising edge reloads N and starts a fresh high phase.
- R13: In BCD mode each decimal digit borrows from the next, so 1000 steps to 0999 and 0000 steps to 9999.
- R14: On cycles with `cnt_tick` low, the count does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address: 0 to 2 counters, 3 control |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0 when this counter is not read |
| cnt_tick | input | 1 | Counting clock enable, one per count period |
| gate | input | 1 | Gate input: enable or trigger, by mode |
| out | output | 1 | Timer output waveform |

## Verification
The bench builds the channel with `CH_ID` left at 0. Counter 0 is therefore the live address, and control bytes naming counter 1 or carrying access field 00 act as foreign bytes that must be ignored. With the 8-bit bus and 16-bit count, a loaded zero gives a 65536-tick low phase in mode 0, and this is short enough to run in full. Odd and even divisors in mode 3, and retriggers in modes 1 and 5, are placed on exact cycles. Holding `cnt_tick` low freezes the count, so two-byte readbacks and single BCD borrows can be checked byte by byte.

// File: rtl/pit_pkg.sv
package pit_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int NIB_N  = CNT_W / 4;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  typedef enum logic [2:0] {
    M_TERM    = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } pit_mode_e;

  function automatic pit_mode_e mode_decode(input logic [2:0] f);
    pit_mode_e m;
    if (f[1]) m = f[0] ? M_SQUARE : M_RATE;
    else begin
      case ({f[2], f[0]})
        2'b00:   m = M_TERM;
        2'b01:   m = M_ONESHOT;
        2'b10:   m = M_SWSTB;
        default: m = M_HWSTB;
      endcase
    end
    return m;
  endfunction

  // Subtract amt (0..3) in binary or per-digit decimal arithmetic, wrapping.
  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] v,
                                                 input logic bcd,
                                                 input logic [1:0] amt);
    logic [CNT_W-1:0] r;
    logic br;
    r = v;
    for (int k = 0; k < 3; k++) begin
      if (k < int'(amt)) begin
        if (!bcd) r = r - CNT_ONE;
        else begin
          br = 1'b1;
          for (int d = 0; d < NIB_N; d++) begin
            if (br) begin
              if (r[d*4 +: 4] == 4'd0) r[d*4 +: 4] = 4'd9;
              else begin
                r[d*4 +: 4] = r[d*4 +: 4] - 4'd1;
                br = 1'b0;
              end
            end
          end
        end
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/pit_bus.sv
module pit_bus
  import pit_pkg::*;
#(
  parameter logic [1:0] CH_ID = 2'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] din,
  input  logic [CNT_W-1:0]  cur_cnt,
  output logic [BYTE_W-1:0] dout,
  output pit_mode_e         mode,
  output logic              bcd,
  output logic              ctl_pulse,
  output logic              ctl_out_init,
  output logic              load_now,
  output logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  init_val
);

  localparam logic [1:0] CTL_ADDR = 2'b11;
  localparam logic [1:0] ACC_LO   = 2'b01;
  localparam logic [1:0] ACC_HI   = 2'b10;
  localparam logic [1:0] ACC_BOTH = 2'b11;

  logic [1:0]       acc_q, acc_d;
  pit_mode_e        mode_q, mode_d;
  logic             bcd_q, bcd_d, cfg_q, cfg_d;
  logic             wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] init_q, init_d;
  logic             ld;
  logic             wr_hit, rd_hit, ctl_hit, dat_wr, dat_rd, hi_sel;

  assign wr_hit  = ~cs_n & ~wr_n;
  assign rd_hit  = ~cs_n & ~rd_n;
  assign ctl_hit = wr_hit && (addr == CTL_ADDR) && (din[7:6] == CH_ID) && (din[5:4] != 2'b00);
  assign dat_wr  = wr_hit && (addr == CH_ID) && cfg_q;
  assign dat_rd  = rd_hit && (addr == CH_ID) && cfg_q;

  always_comb begin
    acc_d  = acc_q;
    mode_d = mode_q;
    bcd_d  = bcd_q;
    cfg_d  = cfg_q;
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    init_d = init_q;
    ld     = 1'b0;
    if (ctl_hit) begin
      acc_d  = din[5:4];
      mode_d = mode_decode(din[3:1]);
      bcd_d  = din[0];
      cfg_d  = 1'b1;
      wptr_d = 1'b0;
      rptr_d = 1'b0;
    end else begin
      if (dat_wr) begin
        case (acc_q)
          ACC_LO: begin
            init_d = {{BYTE_W{1'b0}}, din};
            ld     = 1'b1;
          end
          ACC_HI: begin
            init_d = {din, {BYTE_W{1'b0}}};
            ld     = 1'b1;
          end
          default: begin
            if (!wptr_q) begin
              init_d[BYTE_W-1:0] = din;
              wptr_d             = 1'b1;
            end else begin
              init_d[CNT_W-1:BYTE_W] = din;
              wptr_d                 = 1'b0;
              ld                     = 1'b1;
            end
          end
        endcase
      end
      if (dat_rd && (acc_q == ACC_BOTH)) rptr_d = ~rptr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= ACC_BOTH;
      mode_q <= M_TERM;
      bcd_q  <= 1'b0;
      cfg_q  <= 1'b0;
      wptr_q <= 1'b0;
      rptr_q <= 1'b0;
      init_q <= '0;
    end else begin
      acc_q  <= acc_d;
      mode_q <= mode_d;
      bcd_q  <= bcd_d;
      cfg_q  <= cfg_d;
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      init_q <= init_d;
    end
  end

  assign hi_sel       = (acc_q == ACC_HI) || ((acc_q == ACC_BOTH) && rptr_q);
  assign dout         = !dat_rd ? '0 : (hi_sel ? cur_cnt[CNT_W-1:BYTE_W] : cur_cnt[BYTE_W-1:0]);
  assign mode         = mode_q;
  assign bcd          = bcd_q;
  assign ctl_pulse    = ctl_hit;
  assign ctl_out_init = (mode_decode(din[3:1]) != M_TERM);
  assign load_now     = ld;
  assign load_val     = init_d;
  assign init_val     = init_q;

  // R2: a control byte for another counter leaves the configuration untouched
  a_r2_foreign_ctl_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && addr == CTL_ADDR && din[7:6] != CH_ID) |=> ($stable(mode_q) && $stable(acc_q) && $stable(bcd_q)));

  // R2: with chip select high nothing in the bus state moves
  a_r2_no_cs_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(init_q) && $stable(mode_q) && $stable(wptr_q)));

endmodule

// File: rtl/pit_count.sv
module pit_count
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             gate,
  input  pit_mode_e        mode,
  input  logic             bcd,
  input  logic             ctl_pulse,
  input  logic             ctl_out_init,
  input  logic             load_now,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] init_val,
  output logic [CNT_W-1:0] cnt,
  output logic             out
);

  logic [CNT_W-1:0] cnt_q, cnt_d, dec1, nxt;
  logic             out_q, out_d, armed_q, armed_d, have_q, have_d, gate_q, gate_d;
  logic             rise;
  logic [1:0]       step;

  assign dec1 = cnt_step(cnt_q, bcd, 2'd1);
  assign rise = gate & ~gate_q & have_q;
  assign step = cnt_q[0] ? (out_q ? 2'd1 : 2'd3) : 2'd2;
  assign nxt  = cnt_step(cnt_q, bcd, step);

  always_comb begin
    cnt_d   = cnt_q;
    out_d   = out_q;
    armed_d = armed_q;
    have_d  = have_q;
    gate_d  = tick ? gate : gate_q;
    if (ctl_pulse) begin
      out_d   = ctl_out_init;
      armed_d = 1'b0;
      have_d  = 1'b0;
    end else if (load_now) begin
      cnt_d  = load_val;
      have_d = 1'b1;
      case (mode)
        M_TERM:                     begin out_d = 1'b0; armed_d = 1'b1; end
        M_SWSTB, M_RATE, M_SQUARE:  begin out_d = 1'b1; armed_d = 1'b1; end
        default:                    armed_d = 1'b0;
      endcase
    end else if (tick) begin
      case (mode)
        M_TERM, M_SWSTB: begin
          if (mode == M_SWSTB && !out_q) out_d = 1'b1;
          if (gate) begin
            cnt_d = dec1;
            if (armed_q && dec1 == '0) begin
              armed_d = 1'b0;
              out_d   = (mode == M_TERM);
            end
          end
        end
        M_ONESHOT, M_HWSTB: begin
          if (mode == M_HWSTB && !out_q) out_d = 1'b1;
          if (rise) begin
            cnt_d   = init_val;
            armed_d = 1'b1;
            out_d   = (mode == M_HWSTB);
          end else begin
            cnt_d = dec1;
            if (armed_q && dec1 == '0) begin
              armed_d = 1'b0;
              out_d   = (mode == M_ONESHOT);
            end
          end
        end
        M_RATE: begin
          if (!gate) out_d = 1'b1;
          else if (rise) begin
            cnt_d = init_val;
            out_d = 1'b1;
          end else if (armed_q) begin
            if (cnt_q == CNT_ONE) begin
              cnt_d = init_val;
              out_d = 1'b1;
            end else begin
              cnt_d = dec1;
              out_d = (dec1 != CNT_ONE);
            end
          end
        end
        M_SQUARE: begin
          if (!gate) out_d = 1'b1;
          else if (rise) begin
            cnt_d = init_val;
            out_d = 1'b1;
          end else if (armed_q) begin
            if (nxt == '0) begin
              cnt_d = init_val;
              out_d = ~out_q;
            end else cnt_d = nxt;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      out_q   <= 1'b1;
      armed_q <= 1'b0;
      have_q  <= 1'b0;
      gate_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      out_q   <= out_d;
      armed_q <= armed_d;
      have_q  <= have_d;
      gate_q  <= gate_d;
    end
  end

  assign cnt = cnt_q;
  assign out = out_q;

  // R5: once high in mode 0, the output stays high until reprogrammed
  a_r5_term_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_TERM && out_q && !ctl_pulse && !load_now) |=> out_q);

  // R8: in mode 2 the low pulse lasts a single tick
  a_r8_rate_single_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RATE && !out_q && tick && !ctl_pulse && !load_now) |=> out_q);

  // R10: in mode 4 the strobe lasts a single tick
  a_r10_strobe_single_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SWSTB && !out_q && tick && !ctl_pulse && !load_now) |=> out_q);

  // R12: gate low forces the output high in modes 2 and 3
  a_r12_gate_low_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !gate && (mode == M_RATE || mode == M_SQUARE) && !ctl_pulse && !load_now) |=> out_q);

  // R14: no tick, no load, no count change
  a_r14_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_now) |=> $stable(cnt_q));

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter logic [1:0] CH_ID = 2'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout,
  input  logic              cnt_tick,
  input  logic              gate,
  output logic              out
);

  logic [1:0]       rs_q;
  logic             srst_n;
  pit_mode_e        mode;
  logic             bcd, ctl_pulse, ctl_out_init, load_now;
  logic [CNT_W-1:0] load_val, init_val, cnt;

  // Reset asserts at once and is released two clocks later, in step with clk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  pit_bus #(.CH_ID(CH_ID)) u_bus (
    .clk          (clk),
    .rst_n        (srst_n),
    .cs_n         (cs_n),
    .rd_n         (rd_n),
    .wr_n         (wr_n),
    .addr         (addr),
    .din          (din),
    .cur_cnt      (cnt),
    .dout         (dout),
    .mode         (mode),
    .bcd          (bcd),
    .ctl_pulse    (ctl_pulse),
    .ctl_out_init (ctl_out_init),
    .load_now     (load_now),
    .load_val     (load_val),
    .init_val     (init_val)
  );

  pit_count u_count (
    .clk          (clk),
    .rst_n        (srst_n),
    .tick         (cnt_tick),
    .gate         (gate),
    .mode         (mode),
    .bcd          (bcd),
    .ctl_pulse    (ctl_pulse),
    .ctl_out_init (ctl_out_init),
    .load_now     (load_now),
    .load_val     (load_val),
    .init_val     (init_val),
    .cnt          (cnt),
    .out          (out)
  );

endmodule

// File: tb/pit_channel_bench.sv
module pit_channel_bench;

  logic       clk = 1'b0;
  logic       rst_n, cs_n, rd_n, wr_n, cnt_tick, gate;
  logic [1:0] addr;
  logic [7:0] din, dout;
  logic       out;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  pit_channel u_pit_channel (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .cnt_tick(cnt_tick), .gate(gate), .out(out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // All tasks start and end on a falling clock edge.
  task automatic wr_raw(input logic cs, input logic [1:0] a, input logic [7:0] d);
    cs_n = cs; wr_n = 1'b0; addr = a; din = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_raw(1'b0, a, d);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    #1 d = dout;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic load16(input logic [7:0] lo, input logic [7:0] hi);
    wr(2'd0, lo);
    wr(2'd0, hi);
  endtask

  task automatic run_level(input logic lvl, input int max, output int n);
    n = 0;
    while (out === lvl && n < max) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic gate_pulse();
    gate = 1'b0; @(negedge clk);
    gate = 1'b1; @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 out after reset", int'(out), 1);
    chk("R1 dout idle", int'(dout), 0);
    rd(2'd0, d);
    chk("R1 read before config", int'(d), 0);
  endtask

  task automatic t_formats();
    int n;
    wr(2'd3, 8'h10); wr(2'd0, 8'h05);
    run_level(1'b0, 1000, n); chk("R3 low-only count 5", n, 5);
    wr(2'd3, 8'h20); wr(2'd0, 8'h01);
    run_level(1'b0, 1000, n); chk("R3 high-only count 256", n, 256);
    wr(2'd3, 8'h30); load16(8'h00, 8'h00);
    run_level(1'b0, 70000, n); chk("R3 zero means 65536", n, 65536);
  endtask

  task automatic t_ignore();
    int n;
    wr(2'd3, 8'h30); load16(8'h14, 8'h00);
    wr(2'd3, 8'h74);
    wr(2'd3, 8'h04);
    wr_raw(1'b1, 2'd3, 8'h34);
    chk("R2 out still low after ignored bytes", int'(out), 0);
    run_level(1'b0, 100, n); chk("R2 count unaffected", n, 17);
  endtask

  task automatic t_term_gate();
    int n;
    wr(2'd3, 8'h10); wr(2'd0, 8'h04);
    chk("R5 out low after load", int'(out), 0);
    gate = 1'b0;
    repeat (3) @(negedge clk);
    gate = 1'b1;
    chk("R6 still low while paused", int'(out), 0);
    run_level(1'b0, 100, n); chk("R6 remaining low ticks", n, 4);
    run_level(1'b1, 20, n); chk("R5 stays high", n, 20);
  endtask

  task automatic t_oneshot();
    int n;
    gate = 1'b0;
    wr(2'd3, 8'h32); load16(8'h05, 8'h00);
    chk("R7 no start without edge", int'(out), 1);
    gate = 1'b1; @(negedge clk);
    run_level(1'b0, 100, n); chk("R7 low for N", n, 5);
    run_level(1'b1, 6, n); chk("R7 high after count", n, 6);
    gate_pulse();
    gate = 1'b0; @(negedge clk);
    gate = 1'b1; @(negedge clk);
    run_level(1'b0, 100, n); chk("R7 retrigger restarts", n, 5);
  endtask

  task automatic t_rate();
    int n;
    wr(2'd3, 8'h34); load16(8'h04, 8'h00);
    run_level(1'b1, 100, n); chk("R8 high phase", n, 3);
    run_level(1'b0, 100, n); chk("R8 low pulse", n, 1);
    run_level(1'b1, 100, n); chk("R8 high phase after reload", n, 3);
    run_level(1'b0, 100, n); chk("R8 second low pulse", n, 1);
  endtask

  task automatic t_square();
    int n;
    wr(2'd3, 8'h36); load16(8'h06, 8'h00);
    run_level(1'b1, 100, n); chk("R9 even high", n, 3);
    run_level(1'b0, 100, n); chk("R9 even low", n, 3);
    run_level(1'b1, 100, n); chk("R9 even high again", n, 3);
    wr(2'd3, 8'h36); load16(8'h05, 8'h00);
    run_level(1'b1, 100, n); chk("R9 odd high", n, 3);
    run_level(1'b0, 100, n); chk("R9 odd low", n, 2);
    run_level(1'b1, 100, n); chk("R9 odd high again", n, 3);
    run_level(1'b0, 100, n); chk("R9 odd low again", n, 2);
    gate = 1'b0; @(negedge clk);
    chk("R12 gate low forces high", int'(out), 1);
    run_level(1'b1, 4, n); chk("R12 held high", n, 4);
    gate = 1'b1; @(negedge clk);
    run_level(1'b1, 100, n); chk("R12 rise restarts high phase", n, 3);
  endtask

  task automatic t_strobes();
    int n;
    wr(2'd3, 8'h38); load16(8'h03, 8'h00);
    run_level(1'b1, 100, n); chk("R10 high for N", n, 3);
    run_level(1'b0, 100, n); chk("R10 one low tick", n, 1);
    run_level(1'b1, 10, n); chk("R10 no reload", n, 10);
    gate = 1'b0;
    wr(2'd3, 8'h3A); load16(8'h03, 8'h00);
    run_level(1'b1, 8, n); chk("R11 idle until edge", n, 8);
    gate = 1'b1; @(negedge clk);
    run_level(1'b1, 100, n); chk("R11 high for N", n, 3);
    run_level(1'b0, 100, n); chk("R11 one low tick", n, 1);
    wr(2'd3, 8'h3A); load16(8'h04, 8'h00);
    gate_pulse();
    gate = 1'b0; @(negedge clk);
    gate = 1'b1; @(negedge clk);
    run_level(1'b1, 100, n); chk("R11 retrigger restarts", n, 4);
    run_level(1'b0, 100, n); chk("R11 low after retrigger", n, 1);
  endtask

  task automatic t_readback();
    logic [7:0] d;
    cnt_tick = 1'b0;
    wr(2'd3, 8'h30); load16(8'h34, 8'h12);
    repeat (5) @(negedge clk);
    rd(2'd0, d); chk("R4 first read low byte", int'(d), 'h34);
    rd(2'd0, d); chk("R4 second read high byte", int'(d), 'h12);
    chk("R14 count frozen, out still low", int'(out), 0);
    wr(2'd3, 8'h20); wr(2'd0, 8'hAB);
    rd(2'd0, d); chk("R4 high-only read", int'(d), 'hAB);
    cnt_tick = 1'b1;
  endtask

  task automatic t_bcd();
    logic [7:0] d;
    cnt_tick = 1'b0;
    wr(2'd3, 8'h31); load16(8'h00, 8'h10);
    cnt_tick = 1'b1; @(negedge clk); cnt_tick = 1'b0;
    rd(2'd0, d); chk("R13 1000 step low", int'(d), 'h99);
    rd(2'd0, d); chk("R13 1000 step high", int'(d), 'h09);
    load16(8'h00, 8'h00);
    cnt_tick = 1'b1; @(negedge clk); cnt_tick = 1'b0;
    rd(2'd0, d); chk("R13 0000 wrap low", int'(d), 'h99);
    rd(2'd0, d); chk("R13 0000 wrap high", int'(d), 'h99);
    cnt_tick = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    addr = 2'd0; din = 8'h00; cnt_tick = 1'b1; gate = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_formats();
    t_ignore();
    t_term_gate();
    t_oneshot();
    t_rate();
    t_square();
    t_strobes();
    t_readback();
    t_bcd();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule